// File: doc/BRIEF.md
# Coprocessor Access Alignment Checker

This block sits in the address path of a core's coprocessor load/store issue and of its cache-management operations. Each request brings a 32-bit effective address, an operand-size code, an alignment policy chosen per request, and a flag that marks a cache-management operation. The block decides whether the access must raise an alignment exception. It also produces the address that the memory stage should use.

The block offers three policies. The boundary policy faults only when the operand would spill past a 16-byte line. The strict policy faults when the address is not aligned to a required granule. That granule is either the operand size or a 4-byte word, selected per request. The forcing policy never faults; it zeroes the low address bits that the operand size covers. Cache-management operations ignore the policy entirely. They are masked down to their 32-byte block and never fault.

The result is registered and leaves one cycle after the request, qualified by a response valid. Performing the access and taking the exception are left to the surrounding pipeline.

Top module: `cpa_align_top`

## Requirements
- R1: `req_size_i` encodes the operand length as 0=1, 1=2, 2=4, 3=8 and 4=16 bytes, and codes 5 to 7 act as 16 bytes. `req_policy_i` encodes 0=boundary, 1=strict, 2=forcing, and 3 acts as boundary.
- R2: Under the boundary policy, the exception is raised exactly when the low four address bits plus the operand length exceed 16. A single byte therefore never faults, and a quadword faults on any nonzero low nibble.
- R3: Under the strict policy with `req_strict_word_i`=0, the exception is raised exactly when the address is not a multiple of the operand length.
- R4: Under the strict policy with `req_strict_word_i`=1, the exception is raised exactly when address bits [1:0] are not both zero, whatever the operand size.
- R5: Under the forcing policy, the output address equals the input with its low 0, 1, 2, 3 or 4 bits cleared for lengths 1, 2, 4, 8 and 16, and no exception is raised.
- R6: When `req_cache_op_i`=1, the output address equals the input with bits [4:0] cleared, and no exception is raised, whatever the policy, size or word flag.
- R7: When an exception is raised, the output address equals the input address unchanged.
- R8: Under the boundary and strict policies, the output address equals the input address unchanged for a non-cache request.
- R9: `rsp_valid_o` is high in the cycle after each cycle with `req_valid_i` high and is low otherwise. `rsp_exc_o` is never high while `rsp_valid_o` is low.
- R10: While `rst_ni` is low, and after it is released until the first request, `rsp_valid_o` and `rsp_exc_o` are 0 and `rsp_addr_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Effective address |
| req_size_i | input | 3 | Operand size code |
| req_policy_i | input | 2 | Alignment policy code |
| req_strict_word_i | input | 1 | Strict policy checks word alignment instead of operand size |
| req_cache_op_i | input | 1 | Cache-management operation |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_exc_o | output | 1 | Alignment exception |
| rsp_addr_o | output | 32 | Adjusted (or passed-through) address |

## Verification
Two decisions can land on the same request: the cache-management masking and a policy verdict that would fault on its own. One example is a quadword under the boundary policy at an odd address, or a strict-word request at an unaligned address. The random stream raises the cache flag on about a quarter of requests while the policy, size and address are drawn freely. Directed requests also pair the cache flag with each faulting case. The bench expects the cache masking to win in every such case: no exception, and a 32-byte-aligned address.

// File: rtl/cpa_align_pkg.sv
package cpa_align_pkg;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned POL_W  = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2,
    SZ_DBL  = 3'd3,
    SZ_QUAD = 3'd4
  } op_size_e;

  typedef enum logic [POL_W-1:0] {
    POL_BOUNDARY = 2'd0,
    POL_STRICT   = 2'd1,
    POL_FORCE    = 2'd2,
    POL_RSVD     = 2'd3
  } align_pol_e;
endpackage

// File: rtl/cpa_size_decode.sv
module cpa_size_decode #(
  parameter int unsigned MAX_LG = 4,
  localparam int unsigned LG_W  = $clog2(MAX_LG + 1),
  localparam int unsigned LEN_W = MAX_LG + 1
) (
  input  logic [cpa_align_pkg::SIZE_W-1:0] size_i,
  output logic [LG_W-1:0]                  lg_o,
  output logic [LEN_W-1:0]                 len_o
);
  // Out-of-range codes saturate to the largest operand.
  always_comb begin
    if (32'(size_i) > MAX_LG) lg_o = LG_W'(MAX_LG);
    else                      lg_o = LG_W'(size_i);
    len_o = LEN_W'(1) << lg_o;
  end
endmodule

// File: rtl/cpa_fault_eval.sv
module cpa_fault_eval #(
  parameter int unsigned MAX_LG     = 4,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned LINE_LSB  = $clog2(LINE_BYTES),
  localparam int unsigned LG_W      = $clog2(MAX_LG + 1),
  localparam int unsigned LEN_W     = MAX_LG + 1,
  localparam int unsigned SUM_W     = (LINE_LSB > LEN_W ? LINE_LSB : LEN_W) + 1
) (
  input  logic [LINE_LSB-1:0]             low_i,
  input  logic [LG_W-1:0]                 lg_i,
  input  logic [LEN_W-1:0]                len_i,
  input  cpa_align_pkg::align_pol_e       pol_i,
  input  logic                            strict_word_i,
  output logic                            fault_o
);
  import cpa_align_pkg::*;

  logic [SUM_W-1:0]    end_sum;
  logic                line_cross;
  logic [LEN_W-1:0]    len_mask;
  logic [LINE_LSB-1:0] len_mask_l;
  logic                size_misal;
  logic                word_misal;

  always_comb begin
    end_sum    = SUM_W'(low_i) + SUM_W'(len_i);
    line_cross = end_sum > SUM_W'(LINE_BYTES);
    len_mask   = len_i - LEN_W'(1);
    len_mask_l = LINE_LSB'(len_mask);
    size_misal = |(low_i & len_mask_l);
    word_misal = |low_i[1:0];
  end

  always_comb begin
    unique case (pol_i)
      POL_STRICT: fault_o = strict_word_i ? word_misal : size_misal;
      POL_FORCE:  fault_o = 1'b0;
      default:    fault_o = line_cross;
    endcase
  end

  // R2: single bytes can never straddle a line
  always_comb begin
    if (lg_i == '0 && pol_i != POL_STRICT)
      a_r2_byte_no_cross: assert (!fault_o);
  end
endmodule

// File: rtl/cpa_addr_adjust.sv
module cpa_addr_adjust #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MAX_LG    = 4,
  parameter int unsigned BLOCK_LSB = 5,
  localparam int unsigned LG_W     = $clog2(MAX_LG + 1),
  localparam int unsigned TOP_CLR  = (BLOCK_LSB > MAX_LG) ? BLOCK_LSB : MAX_LG,
  localparam int unsigned CNT_W    = $clog2(TOP_CLR + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LG_W-1:0]   lg_i,
  input  logic              force_i,
  input  logic              cache_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [CNT_W-1:0] clr_cnt;

  always_comb begin
    if (cache_i)      clr_cnt = CNT_W'(BLOCK_LSB);
    else if (force_i) clr_cnt = CNT_W'(lg_i);
    else              clr_cnt = '0;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < TOP_CLR) begin : g_lo
      localparam logic [7:0] IDX = 8'(i);
      assign addr_o[i] = (8'(clr_cnt) > IDX) ? 1'b0 : addr_i[i];
    end else begin : g_hi
      assign addr_o[i] = addr_i[i];
    end
  end
endmodule

// File: rtl/cpa_align_top.sv
module cpa_align_top #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_LG     = 4,
  parameter int unsigned LINE_BYTES = 16,
  parameter int unsigned BLOCK_LSB  = 5,
  localparam int unsigned LINE_LSB  = $clog2(LINE_BYTES),
  localparam int unsigned LG_W      = $clog2(MAX_LG + 1),
  localparam int unsigned LEN_W     = MAX_LG + 1
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_valid_i,
  input  logic [ADDR_W-1:0]                  req_addr_i,
  input  logic [cpa_align_pkg::SIZE_W-1:0]   req_size_i,
  input  logic [cpa_align_pkg::POL_W-1:0]    req_policy_i,
  input  logic                               req_strict_word_i,
  input  logic                               req_cache_op_i,
  output logic                               rsp_valid_o,
  output logic                               rsp_exc_o,
  output logic [ADDR_W-1:0]                  rsp_addr_o
);
  import cpa_align_pkg::*;

  align_pol_e        pol;
  logic [LG_W-1:0]   lg;
  logic [LEN_W-1:0]  len;
  logic              pol_fault;
  logic              fault;
  logic [ADDR_W-1:0] adj_addr;
  logic [ADDR_W-1:0] nxt_addr;

  assign pol = align_pol_e'(req_policy_i);

  cpa_size_decode #(.MAX_LG(MAX_LG)) u_size (
    .size_i (req_size_i),
    .lg_o   (lg),
    .len_o  (len)
  );

  cpa_fault_eval #(.MAX_LG(MAX_LG), .LINE_BYTES(LINE_BYTES)) u_fault (
    .low_i         (req_addr_i[LINE_LSB-1:0]),
    .lg_i          (lg),
    .len_i         (len),
    .pol_i         (pol),
    .strict_word_i (req_strict_word_i),
    .fault_o       (pol_fault)
  );

  cpa_addr_adjust #(.ADDR_W(ADDR_W), .MAX_LG(MAX_LG), .BLOCK_LSB(BLOCK_LSB)) u_adj (
    .addr_i  (req_addr_i),
    .lg_i    (lg),
    .force_i (pol == POL_FORCE),
    .cache_i (req_cache_op_i),
    .addr_o  (adj_addr)
  );

  // Cache operations override any policy verdict.
  always_comb begin
    fault    = pol_fault & ~req_cache_op_i;
    nxt_addr = fault ? req_addr_i : adj_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_exc_o   <= 1'b0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_exc_o   <= req_valid_i & fault;
      if (req_valid_i) rsp_addr_o <= nxt_addr;
    end
  end

  a_r6_cache_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_cache_op_i |=> !rsp_exc_o && rsp_addr_o[BLOCK_LSB-1:0] == '0);

  a_r5_force_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_policy_i == POL_FORCE |=> !rsp_exc_o);

  a_r7_exc_addr_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> !rsp_exc_o || rsp_addr_o == $past(req_addr_i));

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r9_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  a_r9_exc_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !rsp_exc_o);
endmodule

// File: tb/cpa_align_top_tb.sv
module cpa_align_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [2:0]  req_size_i = '0;
  logic [1:0]  req_policy_i = '0;
  logic        req_strict_word_i = 1'b0;
  logic        req_cache_op_i = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_exc_o;
  logic [31:0] rsp_addr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  cpa_align_top u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_size_i, .req_policy_i,
    .req_strict_word_i, .req_cache_op_i, .rsp_valid_o, .rsp_exc_o, .rsp_addr_o
  );

  function automatic logic [32:0] model(input logic [31:0] a, input logic [2:0] sz,
                                        input logic [1:0] pol, input logic sw, input logic cop);
    int lg = (sz > 3'd4) ? 4 : int'(sz);
    int len = 1 << lg;
    logic ex = 1'b0;
    logic [31:0] o = a;
    if (cop) o = a & ~32'h1F;
    else if (pol == 2'd2) o = a & ~((32'd1 << lg) - 32'd1);
    else if (pol == 2'd1) ex = sw ? (a[1:0] != 2'b00) : ((a & 32'(len - 1)) != 0);
    else ex = (int'(a[3:0]) + len) > 16;
    return {ex, o};
  endfunction

  function automatic string req_tag(input logic [1:0] pol, input logic sw, input logic cop);
    if (cop) return "R6";
    if (pol == 2'd2) return "R5";
    if (pol == 2'd1) return sw ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a negedge; check at the following negedge.
  task automatic send(input logic [31:0] a, input logic [2:0] sz, input logic [1:0] pol,
                      input logic sw, input logic cop);
    logic [32:0] e;
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz;
    req_policy_i = pol; req_strict_word_i = sw; req_cache_op_i = cop;
    e = model(a, sz, pol, sw, cop);
    @(negedge clk_i);
    check("R9 valid", 32'(rsp_valid_o), 32'd1);
    check({req_tag(pol, sw, cop), " exc"}, 32'(rsp_exc_o), 32'(e[32]));
    if (e[32]) check("R7 addr", rsp_addr_o, a);
    else if (!cop && pol != 2'd2) check("R8 addr", rsp_addr_o, a);
    else check({req_tag(pol, sw, cop), " addr"}, rsp_addr_o, e[31:0]);
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    req_addr_i = $urandom; req_cache_op_i = 1'b0; req_policy_i = 2'd0; req_size_i = 3'd4;
    @(negedge clk_i);
    check("R9 idle valid", 32'(rsp_valid_o), 32'd0);
    check("R9 idle exc", 32'(rsp_exc_o), 32'd0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R10 valid", 32'(rsp_valid_o), 0);
    check("R10 exc", 32'(rsp_exc_o), 0);
    check("R10 addr", rsp_addr_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 post valid", 32'(rsp_valid_o), 0);
    check("R10 post addr", rsp_addr_o, 0);

    // R2 boundaries for every size
    send(32'h1000_000F, 3'd0, 2'd0, 0, 0);
    send(32'h1000_000F, 3'd1, 2'd0, 0, 0);
    send(32'h1000_000E, 3'd1, 2'd0, 0, 0);
    send(32'h1000_000C, 3'd2, 2'd0, 0, 0);
    send(32'h1000_000D, 3'd2, 2'd0, 0, 0);
    send(32'h1000_0008, 3'd3, 2'd0, 0, 0);
    send(32'h1000_0009, 3'd3, 2'd0, 0, 0);
    send(32'h1000_0010, 3'd4, 2'd0, 0, 0);
    send(32'h1000_0011, 3'd4, 2'd0, 0, 0);
    // R1 saturated size codes and reserved policy
    send(32'h2000_0004, 3'd7, 2'd3, 0, 0);
    send(32'h2000_0020, 3'd5, 2'd1, 0, 0);
    send(32'h2000_0028, 3'd6, 2'd1, 0, 0);
    // R3 / R4
    send(32'h3000_0006, 3'd3, 2'd1, 0, 0);
    send(32'h3000_0006, 3'd1, 2'd1, 0, 0);
    send(32'h3000_0008, 3'd4, 2'd1, 1, 0);
    send(32'h3000_0001, 3'd0, 2'd1, 1, 0);
    send(32'h3000_0001, 3'd0, 2'd1, 0, 0);
    // R5
    send(32'hFFFF_FFFF, 3'd0, 2'd2, 0, 0);
    send(32'hFFFF_FFFF, 3'd2, 2'd2, 1, 0);
    send(32'hFFFF_FFFF, 3'd4, 2'd2, 0, 0);
    // R6 colliding with faulting policies
    send(32'h4000_003F, 3'd4, 2'd0, 0, 1);
    send(32'h4000_0013, 3'd2, 2'd1, 1, 1);
    send(32'h4000_0007, 3'd3, 2'd1, 0, 1);
    send(32'h4000_001F, 3'd1, 2'd2, 0, 1);
    idle();

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else send($urandom, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                1'($urandom), ($urandom_range(0, 3) == 0));
    end
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule